// File: doc/BRIEF.md
# Debug power and reset controller

This block sits on the debug side of a processor and lets an external debugger steer how the core behaves across reset and power-down. A debugger reaches it through a small single-cycle register port that holds a control register and a read-only status register. From the control register the block drives three things. It drives a level request to the system power controller asking it not to really remove power. It drives a fixed-length reset-request pulse meant for an external reset controller. It also drives a hold-in-reset signal for the non-debug core logic.

The block watches three inputs: the system power-on reset, a warm reset, and an indication that the core power domain is off. It reports their live state in the status register and keeps sticky event flags that a debugger clears by reading. The hold-in-reset control survives warm resets, so after a warm reset the core can be kept in reset until the debugger has restored its state. The register port has no back-pressure. Every access with `reg_valid` high completes in that cycle. Read data is combinational and is valid in the same cycle as the access. The port returns zero when no read is in progress.

Top module: `dbg_pwr_rst_ctrl`

## Requirements
- R1: Control bit 0 (keep-power) resets to 0. `no_pwrdn` equals this bit, which a control write sets and which reads back at bit 0.
- R2: Writing 1 to control bit 1 (pulse) drives `rst_req` high for exactly 4 cycles, starting the cycle after the write. A new such write during a pulse restarts the count. Bit 1 always reads 0.
- R3: Control bit 2 (hold) resets to 0. `core_hold_rst` is high while power-on or warm reset is active. It stays high after a warm reset that saw hold=1, and it falls in the cycle after a write clears hold.
- R4: Warm reset leaves control bits 0 and 2 unchanged. Only power-on reset clears them.
- R5: Status bit 0 reads `pd_off`, and status bit 2 reads `core_hold_rst`. Status bits 31:4 read 0.
- R6: Status bit 1 (sticky power-down) is set in the cycle after `pd_off` rises. It is cleared by a status read.
- R7: Status bit 3 (sticky reset) is 1 after power-on reset and is set by any cycle of warm reset. A status read clears it, but a warm reset in the same cycle as the read keeps it set.
- R8: Writes to the status address (1) and accesses to unmapped addresses (2, 3) change nothing and read 0. Control reads (address 0) return 0 in bits 31:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | System power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset of the core, active low, sampled |
| pd_off | input | 1 | Core power domain is off |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 control, 1 status, others unmapped |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| rst_req | output | 1 | Reset request pulse to the reset controller |
| no_pwrdn | output | 1 | Keep-power request to the power controller |
| core_hold_rst | output | 1 | Holds the non-debug core logic in reset |

## Verification
The bench restarts a running pulse with a second write. A design that only arms the pulse from idle would give the wrong length, and one that uses an off-by-one counter would give 3 or 5 cycles. It places a warm reset in the same cycle as a status read. A design where the clear wins would lose the event. It clears hold after an extended warm reset, where a design that latches the hold state without reference to the live bit would keep the core in reset forever. It then raises power-on reset in the middle of the run, which must clear hold and keep-power that the earlier warm resets left alone.

// File: rtl/dprc_pkg.sv
package dprc_pkg;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_STAT = 2'd1;
  // control field positions
  localparam int C_KEEP  = 0;
  localparam int C_PULSE = 1;
  localparam int C_HOLD  = 2;
  // status field positions
  localparam int S_PD    = 0;
  localparam int S_PDSTK = 1;
  localparam int S_RST   = 2;
  localparam int S_RSTK  = 3;
endpackage

// File: rtl/dprc_ctrl.sv
module dprc_ctrl #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic wr_en,
  input  logic wr_keep,
  input  logic wr_pulse,
  input  logic wr_hold,
  output logic no_pwrdn,
  output logic hold_bit,
  output logic rst_req
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] pcnt;

  // keep-power and hold: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      no_pwrdn <= 1'b0;
      hold_bit <= 1'b0;
    end else if (wr_en) begin
      no_pwrdn <= wr_keep;
      hold_bit <= wr_hold;
    end
  end

  // pulse length counter, reloaded by every pulse write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      pcnt <= '0;
    else if (wr_en && wr_pulse)
      pcnt <= CW'(PULSE_LEN);
    else if (pcnt != '0)
      pcnt <= pcnt - 1'b1;
  end

  assign rst_req = (pcnt != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_pulse) |=> rst_req) else $error("pulse not started"); // R2
  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(no_pwrdn) && $stable(hold_bit)) else $error("control moved"); // R4
endmodule

// File: rtl/dprc_status.sv
module dprc_status (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic pd_off,
  input  logic hold_bit,
  input  logic rd_clr,
  output logic core_hold_rst,
  output logic sticky_pd,
  output logic sticky_rst
);
  logic pd_q;
  logic hold_lat;
  logic pd_rise;

  assign pd_rise = pd_off & ~pd_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_q       <= 1'b0;
      hold_lat   <= 1'b0;
      sticky_pd  <= 1'b0;
      sticky_rst <= 1'b1;
    end else begin
      pd_q       <= pd_off;
      hold_lat   <= (~warm_rst_n | hold_lat) & hold_bit;
      sticky_pd  <= pd_rise | (sticky_pd & ~rd_clr);
      sticky_rst <= ~warm_rst_n | (sticky_rst & ~rd_clr);
    end
  end

  assign core_hold_rst = ~por_n | ~warm_rst_n | (hold_lat & hold_bit);

  AST_HOLD_EXTEND: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(warm_rst_n) && hold_bit && $past(hold_bit)) |-> core_hold_rst)
    else $error("hold not extended"); // R3
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pd_off) |=> sticky_pd) else $error("pd event lost"); // R6
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (rd_clr && warm_rst_n) |=> !sticky_rst) else $error("sticky reset not cleared"); // R7
  AST_RST_WINS: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> sticky_rst) else $error("reset event lost"); // R7
endmodule

// File: rtl/dbg_pwr_rst_ctrl.sv
module dbg_pwr_rst_ctrl
  import dprc_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst_n,
  input  logic          pd_off,
  input  logic          reg_valid,
  input  logic          reg_write,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rst_req,
  output logic          no_pwrdn,
  output logic          core_hold_rst
);
  logic wr_ctrl, rd_ctrl, rd_stat;
  logic hold_bit, sticky_pd, sticky_rst;

  assign wr_ctrl = reg_valid &  reg_write & (reg_addr == ADDR_CTRL);
  assign rd_ctrl = reg_valid & ~reg_write & (reg_addr == ADDR_CTRL);
  assign rd_stat = reg_valid & ~reg_write & (reg_addr == ADDR_STAT);

  dprc_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (wr_ctrl),
    .wr_keep  (reg_wdata[C_KEEP]),
    .wr_pulse (reg_wdata[C_PULSE]),
    .wr_hold  (reg_wdata[C_HOLD]),
    .no_pwrdn (no_pwrdn),
    .hold_bit (hold_bit),
    .rst_req  (rst_req)
  );

  dprc_status u_stat (
    .clk           (clk),
    .por_n         (por_n),
    .warm_rst_n    (warm_rst_n),
    .pd_off        (pd_off),
    .hold_bit      (hold_bit),
    .rd_clr        (rd_stat),
    .core_hold_rst (core_hold_rst),
    .sticky_pd     (sticky_pd),
    .sticky_rst    (sticky_rst)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_ctrl) begin
      reg_rdata[C_KEEP] = no_pwrdn;
      reg_rdata[C_HOLD] = hold_bit;
    end else if (rd_stat) begin
      reg_rdata[S_PD]    = pd_off;
      reg_rdata[S_PDSTK] = sticky_pd;
      reg_rdata[S_RST]   = core_hold_rst;
      reg_rdata[S_RSTK]  = sticky_rst;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[DW-1:4] == '0) else $error("reserved bits set"); // R8
  AST_NOPD_FOLLOW: assert property (@(posedge clk) disable iff (!por_n)
    wr_ctrl |=> no_pwrdn == $past(reg_wdata[C_KEEP])) else $error("keep-power mismatch"); // R1
endmodule

// File: tb/dbg_pwr_rst_ctrl_test.sv
`timescale 1ns/1ps
module dbg_pwr_rst_ctrl_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        pd_off = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_req, no_pwrdn, core_hold_rst;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dbg_pwr_rst_ctrl uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .pd_off(pd_off),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req),
    .no_pwrdn(no_pwrdn), .core_hold_rst(core_hold_rst)
  );

  // behavioural reference model
  bit m_keep, m_hold, m_latch, m_spd, m_srst, m_pdprev;
  int m_left;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_keep <= 0; m_hold <= 0; m_latch <= 0; m_spd <= 0; m_srst <= 1;
      m_pdprev <= 0; m_left <= 0;
    end else begin
      bit is_wr, is_rd;
      is_wr = reg_valid && reg_write && reg_addr == 2'd0;
      is_rd = reg_valid && !reg_write && reg_addr == 2'd1;
      if (is_wr) begin
        m_keep <= reg_wdata[0];
        m_hold <= reg_wdata[2];
      end
      if (is_wr && reg_wdata[1]) m_left <= 4;
      else if (m_left > 0) m_left <= m_left - 1;
      if (!warm_rst_n && m_hold) m_latch <= 1;
      else if (!m_hold) m_latch <= 0;
      if (is_wr && !reg_wdata[2]) m_latch <= 0;
      if (pd_off && !m_pdprev) m_spd <= 1;
      else if (is_rd) m_spd <= 0;
      if (!warm_rst_n) m_srst <= 1;
      else if (is_rd) m_srst <= 0;
      m_pdprev <= pd_off;
    end
  end

  function automatic bit exp_hold();
    return !por_n || !warm_rst_n || (m_latch && m_hold);
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    if (reg_valid && !reg_write && reg_addr == 2'd0) begin
      v[0] = m_keep; v[2] = m_hold;
    end else if (reg_valid && !reg_write && reg_addr == 2'd1) begin
      v[0] = pd_off; v[1] = m_spd; v[2] = exp_hold(); v[3] = m_srst;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (!done) begin
      chk("R1 no_pwrdn", {31'b0, no_pwrdn}, {31'b0, m_keep});
      chk("R2 rst_req", {31'b0, rst_req}, {31'b0, m_left > 0});
      chk("R3 core_hold_rst", {31'b0, core_hold_rst}, {31'b0, exp_hold()});
      chk("R5 R6 R7 R8 reg_rdata", reg_rdata, exp_rdata());
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic acc(input bit wr, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; reg_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R3 hold during por", {31'b0, core_hold_rst}, 32'd1);
    chk("R1 keep reset value", {31'b0, no_pwrdn}, 32'd0);
    @(negedge clk); por_n = 1;
    idle(2);
    // R1 keep-power on, read back
    acc(1, 2'd0, 32'h1);
    #5 chk("R1 keep set", {31'b0, no_pwrdn}, 32'd1);
    acc(0, 2'd0, 32'h0);
    // R2 pulse of exactly four cycles
    acc(1, 2'd0, 32'h3);
    for (int i = 0; i < 5; i++) begin
      #5 chk("R2 pulse length", {31'b0, rst_req}, {31'b0, i < 4});
      @(negedge clk);
    end
    // R2 restart mid pulse
    acc(1, 2'd0, 32'h3);
    idle(1);
    acc(1, 2'd0, 32'h3);
    idle(6);
    // R6 power-down event, two reads
    @(negedge clk); pd_off = 1;
    idle(2);
    acc(0, 2'd1, 0);
    acc(0, 2'd1, 0);
    @(negedge clk); pd_off = 0;
    idle(2);
    // R3 hold with warm reset; R4 control survives
    acc(1, 2'd0, 32'h5);
    @(negedge clk); warm_rst_n = 0;
    idle(3);
    @(negedge clk); warm_rst_n = 1;
    idle(3);
    #5 chk("R3 extended hold", {31'b0, core_hold_rst}, 32'd1);
    chk("R4 keep kept over warm reset", {31'b0, no_pwrdn}, 32'd1);
    acc(0, 2'd0, 0);
    acc(0, 2'd1, 0);
    acc(1, 2'd0, 32'h1);
    #5 chk("R3 hold released", {31'b0, core_hold_rst}, 32'd0);
    // R7 warm reset coincident with a status read
    @(negedge clk);
    warm_rst_n = 0; reg_valid = 1; reg_write = 0; reg_addr = 2'd1;
    @(negedge clk);
    warm_rst_n = 1; reg_valid = 0;
    idle(1);
    acc(0, 2'd1, 0);
    acc(0, 2'd1, 0);
    // R8 status write and unmapped addresses ignored
    acc(1, 2'd1, 32'hFFFF_FFFF);
    acc(1, 2'd2, 32'hFFFF_FFFF);
    acc(1, 2'd3, 32'hFFFF_FFFF);
    #5 chk("R8 no pulse from stray writes", {31'b0, rst_req}, 32'd0);
    chk("R8 keep unchanged", {31'b0, no_pwrdn}, 32'd1);
    acc(0, 2'd2, 0);
    acc(0, 2'd0, 0);
    // R4 power-on reset clears hold and keep
    acc(1, 2'd0, 32'h5);
    @(negedge clk); por_n = 0;
    idle(2);
    @(negedge clk); por_n = 1;
    idle(2);
    #5 chk("R4 por clears keep", {31'b0, no_pwrdn}, 32'd0);
    chk("R4 por clears hold", {31'b0, core_hold_rst}, 32'd0);
    acc(0, 2'd1, 0);
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule